// File: doc/BRIEF.md
# DMA Master Region Protection Checker

This block screens every access issued by two DMA bus masters. Sixteen programmable address windows are checked, plus a background permission pair for addresses that fall in no window. Each window has a naturally aligned base, a power-of-two size code, and separate read-deny and write-deny bits for each master. A per-master enable bit in the window decides whether that master looks at the window at all. The pass or block decision is combinational from the address, the master number and the direction, so the fabric can gate the access in the same cycle.

A blocked access never reaches its target. On the next clock edge the block sets that master's sticky error flag and raises a one-cycle pulse for the response chosen for that master. The choices are a silent drop, a bus error, an NMI request or a reset request. Each master's protection unit can be switched off as a whole. While a unit is off, every access from its master passes untouched.

All configuration sits behind a simple word-addressed write port with combinational readback. A key register guards every other register against stray writes.

Top module: `dma_region_guard`

## Requirements
- R1: Out of reset the block is locked (key register at byte 0x00 reads bit0 = 0). While locked, writes to every other register are ignored. Writing 0x000096A5 to 0x00 unlocks and writing 0x000096A4 locks. Any other value leaves the lock state unchanged.
- R2: Window k has its base at byte 0x40+8k (address bits 31:5 kept, bits 4:0 read as zero) and its attributes at 0x44+8k, with the size code n in bits 4:0. The window covers 2^(n+1) bytes, and address bits n:0 of the base are ignored in the compare. A code written below 4 is stored and read back as 4.
- R3: For master m (m = 0 or 1), attribute bit 9+4m denies reads and bit 10+4m denies writes to an enabled window that the access hits.
- R4: When an access hits several enabled windows, it passes only if none of them denies it.
- R5: An access that hits no enabled window uses the master's background bits. The unit register for master m sits at 0x10+4m: bit1 denies reads and bit2 denies writes.
- R6: With the unit enable (bit0 of 0x10+4m) clear, every valid access of master m passes. No flag is set and no response is raised.
- R7: Attribute bit 8+4m enables the window for master m only. A window with that bit clear is invisible to master m.
- R8: The error flag of master m (bit m of 0x3C) is set on the clock edge after a blocked access by m. It holds until a write of 1 to bit m of 0x3C while unlocked. A set in the same cycle wins over the clear.
- R9: Bits 5:4 of 0x10+4m select the response, raised as a one-cycle pulse on the edge after the blocked access: 00 none, 01 bus_err_o[m], 10 nmi_req_o[m], 11 rst_req_o[m].
- R10: acc_allow_o is combinational and high only for a valid access that passes. With acc_valid_i low it is 0 and nothing is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_mst_i | input | 1 | Issuing master: 0 or 1 |
| acc_wr_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | 32 | Byte address of the access |
| acc_allow_o | output | 1 | Access may proceed |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Readback of the addressed register |
| err_flag_o | output | 2 | Sticky per-master error flags |
| bus_err_o | output | 2 | Bus error pulse per master |
| nmi_req_o | output | 2 | NMI request pulse per master |
| rst_req_o | output | 2 | Reset request pulse per master |

## Verification
Directed accesses probe window edges: the last byte before a window, its first and last bytes, and the first byte past it. Each edge is tried with 32-byte, 256-byte and whole-space windows and a base written with stray low bits, which separates mask errors from off-by-one size decoding. Overlapping windows with opposite rights separate any-deny from first-hit logic. A window enabled for one master only, and the background bits, separate the hit path from the fallback path. Each response code, lock-state writes and a flag clear in the same cycle as a new block are run against a behavioural model. A stretch of mixed random reconfiguration and accesses follows, compared on every clock.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam logic [31:0] KEY_OPEN = 32'h0000_96A5;
  localparam logic [31:0] KEY_SHUT = 32'h0000_96A4;
  localparam int GRAN_W   = 5;  // 32-byte minimum window
  localparam int SIZE_MIN = 4;

  typedef enum logic [1:0] {
    ACT_DROP   = 2'b00,
    ACT_BUSERR = 2'b01,
    ACT_NMI    = 2'b10,
    ACT_RESET  = 2'b11
  } act_e;

  typedef struct packed {
    act_e act;
    logic bg_wr_deny;
    logic bg_rd_deny;
    logic en;
  } unit_cfg_t;
endpackage

// File: rtl/dma_guard_match.sv
module dma_guard_match
  import dma_guard_pkg::*;
#(
  parameter int NUM_MST = 2,
  parameter int ADDR_W  = 32,
  parameter int MID_W   = 1
) (
  input  logic [ADDR_W-1:0]      acc_addr_i,
  input  logic [MID_W-1:0]       acc_mst_i,
  input  logic                   acc_wr_i,
  input  logic [ADDR_W-1:GRAN_W] base_i,
  input  logic [4:0]             size_i,
  input  logic [NUM_MST-1:0]     en_i,
  input  logic [NUM_MST-1:0]     rdd_i,
  input  logic [NUM_MST-1:0]     wrd_i,
  output logic                   act_o,
  output logic                   deny_o
);
  logic [ADDR_W-1:0] keep;
  logic              hit;

  // bits above the size code take part in the compare
  always_comb begin
    for (int i = 0; i < ADDR_W; i++) keep[i] = (i > int'(size_i));
  end

  assign hit    = (((acc_addr_i ^ {base_i, {GRAN_W{1'b0}}}) & keep) == '0);
  assign act_o  = hit && en_i[acc_mst_i];
  assign deny_o = act_o && (acc_wr_i ? wrd_i[acc_mst_i] : rdd_i[acc_mst_i]);
endmodule

// File: rtl/dma_guard_regs.sv
module dma_guard_regs
  import dma_guard_pkg::*;
#(
  parameter int NUM_RG  = 16,
  parameter int NUM_MST = 2,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 8,
  parameter int MID_W   = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [CFG_AW-1:0]      cfg_addr_i,
  input  logic [31:0]            cfg_wdata_i,
  output logic [31:0]            cfg_rdata_o,
  input  logic [NUM_MST-1:0]     flag_i,
  output logic                   unlocked_o,
  output logic [NUM_MST-1:0]     flag_clr_o,
  output unit_cfg_t              unit_cfg_o [NUM_MST],
  output logic [ADDR_W-1:GRAN_W] rg_base_o  [NUM_RG],
  output logic [4:0]             rg_size_o  [NUM_RG],
  output logic [NUM_MST-1:0]     rg_en_o    [NUM_RG],
  output logic [NUM_MST-1:0]     rg_rdd_o   [NUM_RG],
  output logic [NUM_MST-1:0]     rg_wrd_o   [NUM_RG]
);
  localparam int WORD_W = CFG_AW - 2;
  localparam int RG_IW  = (NUM_RG > 1) ? $clog2(NUM_RG) : 1;
  localparam logic [WORD_W-1:0] W_KEY   = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_UNIT0 = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_FLAG  = WORD_W'(15);
  localparam logic [WORD_W-1:0] W_RG0   = WORD_W'(16);
  localparam logic [WORD_W-1:0] W_RGEND = WORD_W'(16 + 2 * NUM_RG);

  logic [WORD_W-1:0] word;
  logic              unlocked_q;
  logic              wr_ok;
  logic              unit_sel;
  logic              rg_sel;
  logic [MID_W-1:0]  unit_idx;
  logic [RG_IW-1:0]  rg_idx;
  logic [4:0]        size_in;

  assign word     = cfg_addr_i[CFG_AW-1:2];
  assign wr_ok    = cfg_we_i && unlocked_q && (word != W_KEY);
  assign unit_sel = (word >= W_UNIT0) && (word < W_UNIT0 + WORD_W'(NUM_MST));
  assign rg_sel   = (word >= W_RG0) && (word < W_RGEND);
  assign unit_idx = MID_W'(word - W_UNIT0);
  assign rg_idx   = RG_IW'((word - W_RG0) >> 1);
  assign size_in  = (cfg_wdata_i[4:0] < 5'(SIZE_MIN)) ? 5'(SIZE_MIN) : cfg_wdata_i[4:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
    end else if (cfg_we_i && word == W_KEY) begin
      if (cfg_wdata_i == KEY_OPEN)      unlocked_q <= 1'b1;
      else if (cfg_wdata_i == KEY_SHUT) unlocked_q <= 1'b0;
    end
  end
  assign unlocked_o = unlocked_q;

  assign flag_clr_o = (wr_ok && word == W_FLAG) ? cfg_wdata_i[NUM_MST-1:0] : '0;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_unit
    unit_cfg_t ucfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ucfg_q <= '0;
      end else if (wr_ok && unit_sel && unit_idx == MID_W'(m)) begin
        ucfg_q.en         <= cfg_wdata_i[0];
        ucfg_q.bg_rd_deny <= cfg_wdata_i[1];
        ucfg_q.bg_wr_deny <= cfg_wdata_i[2];
        ucfg_q.act        <= act_e'(cfg_wdata_i[5:4]);
      end
    end
    assign unit_cfg_o[m] = ucfg_q;
  end

  for (genvar k = 0; k < NUM_RG; k++) begin : g_rg
    logic [ADDR_W-1:GRAN_W] base_q;
    logic [4:0]             size_q;
    logic [NUM_MST-1:0]     en_q, rdd_q, wrd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        size_q <= 5'(SIZE_MIN);
        en_q   <= '0;
        rdd_q  <= '0;
        wrd_q  <= '0;
      end else if (wr_ok && rg_sel && rg_idx == RG_IW'(k)) begin
        if (!word[0]) begin
          base_q <= cfg_wdata_i[ADDR_W-1:GRAN_W];
        end else begin
          size_q <= size_in;
          for (int m = 0; m < NUM_MST; m++) begin
            en_q[m]  <= cfg_wdata_i[8 + 4*m];
            rdd_q[m] <= cfg_wdata_i[9 + 4*m];
            wrd_q[m] <= cfg_wdata_i[10 + 4*m];
          end
        end
      end
    end
    assign rg_base_o[k] = base_q;
    assign rg_size_o[k] = size_q;
    assign rg_en_o[k]   = en_q;
    assign rg_rdd_o[k]  = rdd_q;
    assign rg_wrd_o[k]  = wrd_q;
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (word == W_KEY) begin
      cfg_rdata_o[0] = unlocked_q;
    end else if (word == W_FLAG) begin
      cfg_rdata_o[NUM_MST-1:0] = flag_i;
    end else if (unit_sel) begin
      cfg_rdata_o[0]   = unit_cfg_o[unit_idx].en;
      cfg_rdata_o[1]   = unit_cfg_o[unit_idx].bg_rd_deny;
      cfg_rdata_o[2]   = unit_cfg_o[unit_idx].bg_wr_deny;
      cfg_rdata_o[5:4] = unit_cfg_o[unit_idx].act;
    end else if (rg_sel) begin
      if (!word[0]) begin
        cfg_rdata_o[ADDR_W-1:GRAN_W] = rg_base_o[rg_idx];
      end else begin
        cfg_rdata_o[4:0] = rg_size_o[rg_idx];
        for (int m = 0; m < NUM_MST; m++) begin
          cfg_rdata_o[8 + 4*m]  = rg_en_o[rg_idx][m];
          cfg_rdata_o[9 + 4*m]  = rg_rdd_o[rg_idx][m];
          cfg_rdata_o[10 + 4*m] = rg_wrd_o[rg_idx][m];
        end
      end
    end
  end
endmodule

// File: rtl/dma_guard_resp.sv
module dma_guard_resp
  import dma_guard_pkg::*;
#(
  parameter int NUM_RG  = 16,
  parameter int NUM_MST = 2,
  parameter int MID_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [MID_W-1:0]   acc_mst_i,
  input  logic               acc_wr_i,
  input  unit_cfg_t          unit_cfg_i [NUM_MST],
  input  logic [NUM_RG-1:0]  rg_act_i,
  input  logic [NUM_RG-1:0]  rg_deny_i,
  input  logic [NUM_MST-1:0] flag_clr_i,
  output logic               acc_allow_o,
  output logic [NUM_MST-1:0] err_flag_o,
  output logic [NUM_MST-1:0] bus_err_o,
  output logic [NUM_MST-1:0] nmi_req_o,
  output logic [NUM_MST-1:0] rst_req_o
);
  unit_cfg_t cur;
  logic      bg_deny, pass, blocked;

  assign cur     = unit_cfg_i[acc_mst_i];
  assign bg_deny = acc_wr_i ? cur.bg_wr_deny : cur.bg_rd_deny;
  assign pass    = !cur.en || ((|rg_act_i) ? !(|rg_deny_i) : !bg_deny);
  assign blocked = acc_valid_i && cur.en && !pass;
  assign acc_allow_o = acc_valid_i && pass;

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    logic hit_m;
    assign hit_m = blocked && (acc_mst_i == MID_W'(m));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        err_flag_o[m] <= 1'b0;
        bus_err_o[m]  <= 1'b0;
        nmi_req_o[m]  <= 1'b0;
        rst_req_o[m]  <= 1'b0;
      end else begin
        err_flag_o[m] <= hit_m || (err_flag_o[m] && !flag_clr_i[m]);
        bus_err_o[m]  <= hit_m && (unit_cfg_i[m].act == ACT_BUSERR);
        nmi_req_o[m]  <= hit_m && (unit_cfg_i[m].act == ACT_NMI);
        rst_req_o[m]  <= hit_m && (unit_cfg_i[m].act == ACT_RESET);
      end
    end
  end
endmodule

// File: rtl/dma_region_guard.sv
module dma_region_guard
  import dma_guard_pkg::*;
#(
  parameter int NUM_RG  = 16,
  parameter int NUM_MST = 2,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 8,
  localparam int MID_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic [MID_W-1:0]   acc_mst_i,
  input  logic               acc_wr_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  output logic               acc_allow_o,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  output logic [NUM_MST-1:0] err_flag_o,
  output logic [NUM_MST-1:0] bus_err_o,
  output logic [NUM_MST-1:0] nmi_req_o,
  output logic [NUM_MST-1:0] rst_req_o
);
  unit_cfg_t              unit_cfg [NUM_MST];
  logic [ADDR_W-1:GRAN_W] rg_base  [NUM_RG];
  logic [4:0]             rg_size  [NUM_RG];
  logic [NUM_MST-1:0]     rg_en    [NUM_RG];
  logic [NUM_MST-1:0]     rg_rdd   [NUM_RG];
  logic [NUM_MST-1:0]     rg_wrd   [NUM_RG];
  logic [NUM_RG-1:0]      rg_act, rg_deny;
  logic [NUM_MST-1:0]     flag_clr;
  logic                   unlocked;
  logic [NUM_MST-1:0]     unit_en;
  logic [NUM_MST*5-1:0]   ucfg_flat;

  dma_guard_regs #(
    .NUM_RG(NUM_RG), .NUM_MST(NUM_MST), .ADDR_W(ADDR_W),
    .CFG_AW(CFG_AW), .MID_W(MID_W)
  ) i_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .flag_i     (err_flag_o),
    .unlocked_o (unlocked),
    .flag_clr_o (flag_clr),
    .unit_cfg_o (unit_cfg),
    .rg_base_o  (rg_base),
    .rg_size_o  (rg_size),
    .rg_en_o    (rg_en),
    .rg_rdd_o   (rg_rdd),
    .rg_wrd_o   (rg_wrd)
  );

  for (genvar k = 0; k < NUM_RG; k++) begin : g_match
    dma_guard_match #(.NUM_MST(NUM_MST), .ADDR_W(ADDR_W), .MID_W(MID_W)) i_match (
      .acc_addr_i, .acc_mst_i, .acc_wr_i,
      .base_i (rg_base[k]),
      .size_i (rg_size[k]),
      .en_i   (rg_en[k]),
      .rdd_i  (rg_rdd[k]),
      .wrd_i  (rg_wrd[k]),
      .act_o  (rg_act[k]),
      .deny_o (rg_deny[k])
    );
  end

  dma_guard_resp #(.NUM_RG(NUM_RG), .NUM_MST(NUM_MST), .MID_W(MID_W)) i_resp (
    .clk_i, .rst_ni, .acc_valid_i, .acc_mst_i, .acc_wr_i,
    .unit_cfg_i (unit_cfg),
    .rg_act_i   (rg_act),
    .rg_deny_i  (rg_deny),
    .flag_clr_i (flag_clr),
    .acc_allow_o, .err_flag_o, .bus_err_o, .nmi_req_o, .rst_req_o
  );

  for (genvar m = 0; m < NUM_MST; m++) begin : g_view
    assign unit_en[m]           = unit_cfg[m].en;
    assign ucfg_flat[m*5 +: 5]  = unit_cfg[m];
  end
endmodule

// File: rtl/dma_region_guard_chk.sv
module dma_region_guard_chk #(
  parameter int NUM_MST = 2,
  parameter int MID_W   = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_valid_i,
  input logic [MID_W-1:0]   acc_mst_i,
  input logic               acc_allow_o,
  input logic [NUM_MST-1:0] err_flag_o,
  input logic [NUM_MST-1:0] bus_err_o,
  input logic [NUM_MST-1:0] nmi_req_o,
  input logic [NUM_MST-1:0] rst_req_o,
  input logic               unlocked,
  input logic [NUM_MST-1:0] unit_en,
  input logic [NUM_MST*5-1:0] ucfg_flat,
  input logic [NUM_MST-1:0] flag_clr
);
  // R10
  allow_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_allow_o |-> acc_valid_i);

  // R1
  locked_cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(ucfg_flat));

  for (genvar m = 0; m < NUM_MST; m++) begin : g_m
    // R9
    one_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({bus_err_o[m], nmi_req_o[m], rst_req_o[m]}));

    // R9
    response_has_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_err_o[m] || nmi_req_o[m] || rst_req_o[m]) |-> err_flag_o[m]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_flag_o[m] && !flag_clr[m]) |=> err_flag_o[m]);

    // R6
    unit_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc_valid_i && acc_mst_i == MID_W'(m) && !unit_en[m] && !err_flag_o[m])
      |=> !(err_flag_o[m] || bus_err_o[m] || nmi_req_o[m] || rst_req_o[m]));
  end
endmodule

bind dma_region_guard dma_region_guard_chk #(.NUM_MST(NUM_MST), .MID_W(MID_W)) i_chk (.*);

// File: tb/test_dma_region_guard.sv
`timescale 1ns/1ps
module test_dma_region_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [0:0]  acc_mst_i = '0;
  logic        acc_wr_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_allow_o;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [1:0]  err_flag_o, bus_err_o, nmi_req_o, rst_req_o;

  always #2 clk_i = ~clk_i;

  dma_region_guard i_dma_region_guard (.*);

  int    compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit    run_cmp = 0, done = 0;

  // reference model state
  bit        m_unl;
  bit        m_uen[2], m_bgrd[2], m_bgwr[2];
  bit [1:0]  m_act[2];
  bit [31:0] m_base[16];
  int        m_size[16];
  bit        m_en[16][2], m_rdd[16][2], m_wrd[16][2];
  bit [1:0]  m_flag, m_be, m_nmi, m_rst;

  function automatic bit exp_pass();
    int  mi;
    bit  any, den;
    longint unsigned span;
    if (!acc_valid_i) return 1'b0;
    mi = int'(acc_mst_i);
    if (!m_uen[mi]) return 1'b1;
    any = 0; den = 0;
    for (int k = 0; k < 16; k++) begin
      if (m_en[k][mi]) begin
        span = 64'd1 << (m_size[k] + 1);
        if ((longint'(acc_addr_i) / span) == (longint'(m_base[k]) / span)) begin
          any = 1;
          if (acc_wr_i ? m_wrd[k][mi] : m_rdd[k][mi]) den = 1;
        end
      end
    end
    if (any) return !den;
    return !(acc_wr_i ? m_bgwr[mi] : m_bgrd[mi]);
  endfunction

  function automatic bit [31:0] exp_rdata();
    int w, k;
    bit [31:0] r;
    w = int'(cfg_addr_i[7:2]);
    r = '0;
    if (w == 0) r[0] = m_unl;
    else if (w == 4 || w == 5) r = {26'b0, m_act[w-4], 1'b0, m_bgwr[w-4], m_bgrd[w-4], m_uen[w-4]};
    else if (w == 15) r[1:0] = m_flag;
    else if (w >= 16 && w < 48) begin
      k = (w - 16) / 2;
      if (w % 2 == 0) r = m_base[k];
      else begin
        r[4:0] = 5'(m_size[k]);
        for (int m = 0; m < 2; m++) begin
          r[8+4*m] = m_en[k][m]; r[9+4*m] = m_rdd[k][m]; r[10+4*m] = m_wrd[k][m];
        end
      end
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_unl = 0; m_flag = 0; m_be = 0; m_nmi = 0; m_rst = 0;
      for (int m = 0; m < 2; m++) begin m_uen[m] = 0; m_bgrd[m] = 0; m_bgwr[m] = 0; m_act[m] = 0; end
      for (int k = 0; k < 16; k++) begin
        m_base[k] = 0; m_size[k] = 4;
        for (int m = 0; m < 2; m++) begin m_en[k][m] = 0; m_rdd[k][m] = 0; m_wrd[k][m] = 0; end
      end
    end else begin
      bit blk;
      int w, mi, k;
      bit [1:0] clr;
      mi  = int'(acc_mst_i);
      blk = acc_valid_i && m_uen[mi] && !exp_pass();
      w   = int'(cfg_addr_i[7:2]);
      clr = 0; m_be = 0; m_nmi = 0; m_rst = 0;
      if (cfg_we_i && m_unl && w == 15) clr = cfg_wdata_i[1:0];
      m_flag = m_flag & ~clr;
      if (blk) begin
        m_flag[mi] = 1;
        case (m_act[mi])
          2'd1: m_be[mi] = 1;
          2'd2: m_nmi[mi] = 1;
          2'd3: m_rst[mi] = 1;
          default: ;
        endcase
      end
      if (cfg_we_i) begin
        if (w == 0) begin
          if (cfg_wdata_i == 32'h96A5) m_unl = 1;
          else if (cfg_wdata_i == 32'h96A4) m_unl = 0;
        end else if (m_unl) begin
          if (w == 4 || w == 5) begin
            m_uen[w-4] = cfg_wdata_i[0]; m_bgrd[w-4] = cfg_wdata_i[1];
            m_bgwr[w-4] = cfg_wdata_i[2]; m_act[w-4] = cfg_wdata_i[5:4];
          end else if (w >= 16 && w < 48) begin
            k = (w - 16) / 2;
            if (w % 2 == 0) m_base[k] = cfg_wdata_i & 32'hFFFF_FFE0;
            else begin
              m_size[k] = (cfg_wdata_i[4:0] < 4) ? 4 : int'(cfg_wdata_i[4:0]);
              for (int m = 0; m < 2; m++) begin
                m_en[k][m] = cfg_wdata_i[8+4*m]; m_rdd[k][m] = cfg_wdata_i[9+4*m];
                m_wrd[k][m] = cfg_wdata_i[10+4*m];
              end
            end
          end
        end
      end
    end
  end

  task automatic chk(input string what, input bit [31:0] act, input bit [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    if (run_cmp && !done) begin
      chk("acc_allow_o", 32'(acc_allow_o), 32'(exp_pass()));
      chk("cfg_rdata_o", cfg_rdata_o, exp_rdata());
      chk("err_flag_o", 32'(err_flag_o), 32'(m_flag));
      chk("bus_err_o", 32'(bus_err_o), 32'(m_be));
      chk("nmi_req_o", 32'(nmi_req_o), 32'(m_nmi));
      chk("rst_req_o", 32'(rst_req_o), 32'(m_rst));
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk_i); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic rd(input bit [7:0] a);
    @(negedge clk_i); cfg_addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic acc(input bit v, input bit m, input bit w, input bit [31:0] a);
    @(negedge clk_i); acc_valid_i = v; acc_mst_i = m; acc_wr_i = w; acc_addr_i = a;
    @(negedge clk_i); acc_valid_i = 0;
  endtask

  task automatic ucfg(input int m, input bit en, input bit brd, input bit bwr, input bit [1:0] act);
    wr(8'(8'h10 + 4*m), {26'b0, act, 1'b0, bwr, brd, en});
  endtask

  task automatic rg(input int k, input bit [31:0] base, input bit [4:0] sz,
                    input bit e0, input bit r0, input bit w0, input bit e1, input bit r1, input bit w1);
    wr(8'(8'h40 + 8*k), base);
    wr(8'(8'h44 + 8*k), {17'b0, w1, r1, e1, 1'b0, w0, r0, e0, 3'b0, sz});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1; run_cmp = 1;
    // R1: reset state and lock behaviour
    cur_req = "R1";
    rd(8'h00); rd(8'h10);
    ucfg(0, 1, 1, 1, 3); rd(8'h10);
    wr(8'h00, 32'h1234); rd(8'h00);
    wr(8'h00, 32'h96A5); rd(8'h00);
    wr(8'h00, 32'h96A4); ucfg(0, 1, 1, 1, 3); rd(8'h10);
    wr(8'h00, 32'h96A5);
    // R6: whole space denied, unit off
    cur_req = "R6";
    rg(0, 32'h0, 5'h1F, 1, 1, 1, 1, 1, 1);
    ucfg(0, 0, 1, 1, 1); ucfg(1, 0, 1, 1, 2);
    acc(1, 0, 0, 32'h1000_0000); acc(1, 0, 1, 32'hFFFF_FFFC); acc(1, 1, 1, 32'h0);
    rd(8'h3C);
    // R10: no valid, no effect
    cur_req = "R10";
    ucfg(0, 1, 1, 1, 1);
    acc(0, 0, 1, 32'h1000_0000); rd(8'h3C);
    acc(1, 0, 1, 32'h1000_0000); rd(8'h3C);
    wr(8'h3C, 32'h3);
    rg(0, 32'h0, 5'h1F, 0, 0, 0, 0, 0, 0);
    // R3: per-master rights
    cur_req = "R3";
    ucfg(0, 1, 0, 0, 1); ucfg(1, 1, 0, 0, 2);
    rg(1, 32'h2000_01E7, 5'h07, 1, 1, 0, 1, 0, 1);
    acc(1, 0, 0, 32'h2000_0100); acc(1, 0, 1, 32'h2000_0100);
    acc(1, 1, 0, 32'h2000_0180); acc(1, 1, 1, 32'h2000_0180);
    // R2: edges and size coding
    cur_req = "R2";
    rd(8'h48); rd(8'h4C);
    acc(1, 0, 0, 32'h2000_00FF); acc(1, 0, 0, 32'h2000_01FF); acc(1, 0, 0, 32'h2000_0200);
    wr(8'h54, 32'h0000_0102); rd(8'h54);
    rg(3, 32'h3000_0040, 5'h04, 1, 1, 0, 0, 0, 0);
    acc(1, 0, 0, 32'h3000_003F); acc(1, 0, 0, 32'h3000_0040);
    acc(1, 0, 0, 32'h3000_005F); acc(1, 0, 0, 32'h3000_0060);
    // R4: overlapping windows
    cur_req = "R4";
    rg(4, 32'h4000_0000, 5'h0B, 1, 0, 0, 1, 0, 0);
    rg(5, 32'h4000_0800, 5'h07, 1, 0, 1, 0, 0, 0);
    acc(1, 0, 1, 32'h4000_0000); acc(1, 0, 1, 32'h4000_0800);
    acc(1, 0, 0, 32'h4000_0800); acc(1, 1, 1, 32'h4000_0800);
    // R5: background space
    cur_req = "R5";
    ucfg(0, 1, 1, 0, 1); ucfg(1, 1, 0, 1, 2);
    acc(1, 0, 0, 32'h5000_0000); acc(1, 0, 1, 32'h5000_0000);
    acc(1, 1, 0, 32'h5000_0000); acc(1, 1, 1, 32'h5000_0000);
    // R7: window enabled for one master only
    cur_req = "R7";
    ucfg(0, 1, 0, 0, 1);
    rg(6, 32'h6000_0000, 5'h08, 0, 1, 1, 1, 1, 0);
    acc(1, 0, 0, 32'h6000_0010); acc(1, 1, 0, 32'h6000_0010);
    // R8: sticky flag, clear, lock, set wins
    cur_req = "R8";
    rd(8'h3C); wr(8'h3C, 32'h1); rd(8'h3C);
    wr(8'h00, 32'h96A4); wr(8'h3C, 32'h3); rd(8'h3C); wr(8'h00, 32'h96A5);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 8'h3C; cfg_wdata_i = 32'h2;
    acc_valid_i = 1; acc_mst_i = 1; acc_wr_i = 0; acc_addr_i = 32'h6000_0020;
    @(negedge clk_i); cfg_we_i = 0; acc_valid_i = 0;
    rd(8'h3C);
    // R9: each response code
    cur_req = "R9";
    for (int a = 0; a < 4; a++) begin
      ucfg(0, 1, 1, 1, 2'(a));
      acc(1, 0, 0, 32'h7000_0000);
      acc(1, 0, 1, 32'h7000_0040);
    end
    // mixed random traffic
    cur_req = "R4";
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) begin
        int k;
        k = int'($urandom_range(0, 15));
        rg(k, {3'(k % 5 + 2), 29'($urandom) & 29'h0000_1FFF}, 5'($urandom_range(2, 13)),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end else if (sel == 1) begin
        ucfg(int'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), 1'($urandom),
             1'($urandom), 2'($urandom));
      end else if (sel == 2) begin
        wr(8'h3C, 32'($urandom_range(0, 3)));
      end else begin
        @(negedge clk_i);
        cfg_addr_i = 8'($urandom_range(0, 63) * 4);
        acc_valid_i = 1; acc_mst_i = 1'($urandom); acc_wr_i = 1'($urandom);
        acc_addr_i = {3'($urandom_range(2, 6)), 29'($urandom) & 29'h0000_1FFF};
        @(negedge clk_i); acc_valid_i = 0;
      end
    end
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule